// File: doc/BRIEF.md
# Bit-Serial Half-Precision Floating-Point Adder

This block adds two half-precision floating-point numbers that reach it one bit per clock. Each operand travels on its own lane of two wires. The significand wire carries eleven bits with the leading one written out. The sign/exponent wire carries the five exponent bits followed by the sign, in step with the first six significand beats. The block works in three phases, in this order. First it aligns the smaller operand and rounds it to nearest-even while it shifts it. Then it adds or subtracts the significands one bit per cycle through a single carry flop. Last it normalises the sum.

Each lane is a valid/ready stream. A beat transfers on a cycle where both the lane's valid and ready are high. Ready falls once the lane holds a full operand and stays low until the result has been sent. The sender must therefore hold a beat's data for as long as valid is high and ready is low. The two lanes fill on their own schedules. The result leaves on the same two-wire serial format and has no back-pressure: the sink must take one beat per cycle while the result valid is high. A one-cycle done strobe marks the first result beat. Only normal numbers are handled. The sender keeps operand exponents in the range 1 to 29.

Top module: `fpser_add`

## Requirements
- R1: Operand beat k (k = 0..10) carries significand bit k, least significant first, with bit 10 being the leading one. On beats 0..4 the sign/exponent wire carries exponent bits 0..4, and on beat 5 it carries the sign (1 = negative). It is ignored on beats 6..10.
- R2: A lane's ready is high only while the block is idle and that lane holds fewer than 11 beats. Beats offered while ready is low change nothing.
- R3: The operand with the larger {exponent, significand} value is kept as is. The other significand is shifted right by the exponent difference and rounded to nearest, ties to even, from the guard bit and the OR of all lower shifted-out bits.
- R4: Equal signs add the significands and different signs subtract the aligned smaller one from the larger. The result sign is the sign of the larger operand.
- R5: A carry out of bit 10 after an addition shifts the sum right by one, dropping the low bit without rounding, and adds one to the exponent.
- R6: Otherwise the sum is shifted left one place per cycle until bit 10 is one, and each shift lowers the exponent by one.
- R7: An exact zero sum yields +0: sign 0, exponent 0, significand 0.
- R8: If a left shift would be needed while the exponent is 1, the result is flushed to +0.
- R9: The result is sent over 11 consecutive cycles with res_vld high, in the operand format of R1. res_se_vld is high on the first six of those cycles, and res_done is high on the first only.
- R10: res_done rises 12 + n clock edges after the edge that accepts the last operand beat. Here n = 1 plus the number of normalisation steps: one for a carry shift (R5), one for each left shift (R6), and none for a zero or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Operand A beat valid |
| a_rdy | output | 1 | Operand A lane can take a beat |
| a_man | input | 1 | Operand A significand bit |
| a_se | input | 1 | Operand A sign/exponent bit |
| b_vld | input | 1 | Operand B beat valid |
| b_rdy | output | 1 | Operand B lane can take a beat |
| b_man | input | 1 | Operand B significand bit |
| b_se | input | 1 | Operand B sign/exponent bit |
| res_vld | output | 1 | Result beat present |
| res_man | output | 1 | Result significand bit |
| res_se_vld | output | 1 | Result sign/exponent bit present |
| res_se | output | 1 | Result sign/exponent bit |
| res_done | output | 1 | First result beat strobe |

## Verification
The result timing depends on the data. After the last operand beat, there is one alignment edge and eleven serial-add edges. Normalisation then takes one edge plus one edge for each shift, so res_done is due 12 + n edges later. The bench works out n from its own arithmetic model for every operation, counts edges from the accepting edge, and requires res_done exactly there. It then reads the following ten beats on the following cycles and checks the cycle after them for a dropped valid and restored ready.

// File: rtl/fpser_pkg.sv
package fpser_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_ADD  = 2'd1,
    ST_NORM = 2'd2,
    ST_OUT  = 2'd3
  } fps_state_e;
endpackage

// File: rtl/fpser_lane.sv
module fpser_lane #(
  parameter int MAN_W = 11,
  parameter int SE_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic             man_bit,
  input  logic             se_bit,
  output logic             full,
  output logic [MAN_W-1:0] man,
  output logic [SE_W-1:0]  se
);
  localparam int CW = $clog2(MAN_W + 1);

  logic [CW-1:0] cnt;
  logic          acc;

  assign full   = (cnt == CW'(MAN_W));
  assign in_rdy = en && !full;
  assign acc    = in_vld && in_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      man <= '0;
      se  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (acc) begin
      cnt <= cnt + CW'(1);
      man <= {man_bit, man[MAN_W-1:1]};
      if (cnt < CW'(SE_W)) se <= {se_bit, se[SE_W-1:1]};
    end
  end
endmodule

// File: rtl/fpser_align.sv
module fpser_align #(
  parameter int MAN_W = 11,
  parameter int EXP_W = 5
) (
  input  logic [MAN_W-1:0] a_man,
  input  logic [EXP_W:0]   a_se,
  input  logic [MAN_W-1:0] b_man,
  input  logic [EXP_W:0]   b_se,
  output logic [MAN_W-1:0] big_man,
  output logic [MAN_W-1:0] small_man,
  output logic [EXP_W-1:0] exp_o,
  output logic             sign_o,
  output logic             sub_o
);
  localparam int XW = 2 * MAN_W + 2;

  logic             swap;
  logic [MAN_W-1:0] s_man;
  logic [EXP_W-1:0] s_exp, diff;
  logic [XW-1:0]    ext;
  logic [MAN_W-1:0] kept;
  logic             guard, rest, up;

  assign swap    = {b_se[EXP_W-1:0], b_man} > {a_se[EXP_W-1:0], a_man};
  assign big_man = swap ? b_man : a_man;
  assign s_man   = swap ? a_man : b_man;
  assign exp_o   = swap ? b_se[EXP_W-1:0] : a_se[EXP_W-1:0];
  assign s_exp   = swap ? a_se[EXP_W-1:0] : b_se[EXP_W-1:0];
  assign sign_o  = swap ? b_se[EXP_W] : a_se[EXP_W];
  assign sub_o   = a_se[EXP_W] ^ b_se[EXP_W];
  assign diff    = exp_o - s_exp;

  // Shifted value keeps MAN_W result bits, a guard bit and the lower sticky field.
  assign ext       = {s_man, {(MAN_W + 2){1'b0}}} >> diff;
  assign kept      = ext[XW-1 -: MAN_W];
  assign guard     = ext[MAN_W+1];
  assign rest      = |ext[MAN_W:0];
  assign up        = guard && (rest || kept[0]);
  assign small_man = kept + MAN_W'(up);
endmodule

// File: rtl/fpser_bitadd.sv
module fpser_bitadd (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cin,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  logic carry;

  assign s  = a ^ b ^ carry;
  assign co = (a & b) | (a & carry) | (b & carry);

  always_ff @(posedge clk) begin
    if (!rst_n)    carry <= 1'b0;
    else if (load) carry <= cin;
    else if (en)   carry <= co;
  end
endmodule

// File: rtl/fpser_add.sv
module fpser_add #(
  parameter int MAN_W = 11,
  parameter int EXP_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_vld,
  output logic a_rdy,
  input  logic a_man,
  input  logic a_se,
  input  logic b_vld,
  output logic b_rdy,
  input  logic b_man,
  input  logic b_se,
  output logic res_vld,
  output logic res_man,
  output logic res_se_vld,
  output logic res_se,
  output logic res_done
);
  import fpser_pkg::*;

  localparam int SE_W = EXP_W + 1;
  localparam int CW   = $clog2(MAN_W + 1);

  fps_state_e       st;
  logic [CW-1:0]    cnt;
  logic [MAN_W-1:0] big, sm, sum;
  logic [EXP_W-1:0] exp_r;
  logic [SE_W-1:0]  seo;
  logic             sgn, sub, ovf;
  logic             take;

  logic [1:0]       ln_vld, ln_rdy, ln_mbit, ln_sbit, ln_full;
  logic [MAN_W-1:0] ln_man [2];
  logic [SE_W-1:0]  ln_se  [2];

  assign ln_vld  = {b_vld, a_vld};
  assign ln_mbit = {b_man, a_man};
  assign ln_sbit = {b_se, a_se};
  assign a_rdy   = ln_rdy[0];
  assign b_rdy   = ln_rdy[1];
  assign take    = (st == ST_LOAD) && (&ln_full);

  for (genvar i = 0; i < 2; i++) begin : g_lane
    fpser_lane #(.MAN_W(MAN_W), .SE_W(SE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (st == ST_LOAD),
      .clr    (take),
      .in_vld (ln_vld[i]),
      .in_rdy (ln_rdy[i]),
      .man_bit(ln_mbit[i]),
      .se_bit (ln_sbit[i]),
      .full   (ln_full[i]),
      .man    (ln_man[i]),
      .se     (ln_se[i])
    );
  end

  logic [MAN_W-1:0] al_big, al_small;
  logic [EXP_W-1:0] al_exp;
  logic             al_sign, al_sub;

  fpser_align #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_align (
    .a_man    (ln_man[0]),
    .a_se     (ln_se[0]),
    .b_man    (ln_man[1]),
    .b_se     (ln_se[1]),
    .big_man  (al_big),
    .small_man(al_small),
    .exp_o    (al_exp),
    .sign_o   (al_sign),
    .sub_o    (al_sub)
  );

  logic fa_s, fa_co;

  // Subtraction feeds the inverted small significand with a carry-in of one.
  fpser_bitadd u_fa (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take),
    .cin  (al_sub),
    .en   (st == ST_ADD),
    .a    (big[0]),
    .b    (sm[0] ^ sub),
    .s    (fa_s),
    .co   (fa_co)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_LOAD;
      cnt   <= '0;
      big   <= '0;
      sm    <= '0;
      sum   <= '0;
      exp_r <= '0;
      seo   <= '0;
      sgn   <= 1'b0;
      sub   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      unique case (st)
        ST_LOAD: if (take) begin
          big   <= al_big;
          sm    <= al_small;
          exp_r <= al_exp;
          sgn   <= al_sign;
          sub   <= al_sub;
          cnt   <= '0;
          st    <= ST_ADD;
        end
        ST_ADD: begin
          big <= big >> 1;
          sm  <= sm >> 1;
          sum <= {fa_s, sum[MAN_W-1:1]};
          cnt <= cnt + CW'(1);
          if (cnt == CW'(MAN_W - 1)) begin
            ovf <= fa_co & ~sub;
            st  <= ST_NORM;
          end
        end
        ST_NORM: begin
          cnt <= '0;
          if (ovf) begin
            sum   <= {1'b1, sum[MAN_W-1:1]};
            exp_r <= exp_r + EXP_W'(1);
            ovf   <= 1'b0;
          end else if (sum == '0 || (!sum[MAN_W-1] && exp_r == EXP_W'(1))) begin
            sum <= '0;
            seo <= '0;
            st  <= ST_OUT;
          end else if (sum[MAN_W-1]) begin
            seo <= {sgn, exp_r};
            st  <= ST_OUT;
          end else begin
            sum   <= sum << 1;
            exp_r <= exp_r - EXP_W'(1);
          end
        end
        ST_OUT: begin
          sum <= sum >> 1;
          seo <= seo >> 1;
          cnt <= cnt + CW'(1);
          if (cnt == CW'(MAN_W - 1)) st <= ST_LOAD;
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  assign res_vld    = (st == ST_OUT);
  assign res_done   = res_vld && (cnt == '0);
  assign res_se_vld = res_vld && (cnt < CW'(SE_W));
  assign res_man    = res_vld && sum[0];
  assign res_se     = res_se_vld && seo[0];
endmodule

// File: rtl/fpser_add_chk.sv
module fpser_add_chk #(
  parameter int MAN_W = 11,
  parameter int EXP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_vld,
  input logic             res_done,
  input logic             res_se_vld,
  input logic             a_rdy,
  input logic             b_rdy,
  input logic [MAN_W-1:0] sum,
  input logic [EXP_W:0]   seo
);
  a_r9_done_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_vld);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  a_r9_se_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
    res_se_vld |-> res_vld);

  a_r9_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_vld) |-> res_done);

  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (!a_rdy && !b_rdy));

  a_r6_normalized: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && seo[EXP_W-1:0] != '0) |-> sum[MAN_W-1]);

  a_r7_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && seo[EXP_W-1:0] == '0) |-> (sum == '0 && !seo[EXP_W]));
endmodule

bind fpser_add fpser_add_chk #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_vld   (res_vld),
  .res_done  (res_done),
  .res_se_vld(res_se_vld),
  .a_rdy     (a_rdy),
  .b_rdy     (b_rdy),
  .sum       (sum),
  .seo       (seo)
);

// File: tb/fpser_add_tb.sv
module fpser_add_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_vld = 1'b0, a_man = 1'b0, a_se = 1'b0;
  logic b_vld = 1'b0, b_man = 1'b0, b_se = 1'b0;
  logic a_rdy, b_rdy, res_vld, res_man, res_se_vld, res_se, res_done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fpser_add u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_rdy(a_rdy), .a_man(a_man), .a_se(a_se),
    .b_vld(b_vld), .b_rdy(b_rdy), .b_man(b_man), .b_se(b_se),
    .res_vld(res_vld), .res_man(res_man), .res_se_vld(res_se_vld),
    .res_se(res_se), .res_done(res_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of the requirements; ncyc is n of R10.
  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          output int ncyc, output string cat);
    int am, bm, bigm, smm, bige, sme, d, full, kept, g, rest, al, s, e;
    logic bs, sub, swap;
    am = 1024 + int'(a[9:0]);
    bm = 1024 + int'(b[9:0]);
    swap = b[14:0] > a[14:0];
    bigm = swap ? bm : am;
    smm  = swap ? am : bm;
    bige = swap ? int'(b[14:10]) : int'(a[14:10]);
    sme  = swap ? int'(a[14:10]) : int'(b[14:10]);
    bs   = swap ? b[15] : a[15];
    sub  = a[15] ^ b[15];
    d    = bige - sme;
    full = (smm * 8192) >> d;
    kept = full >> 13;
    g    = (full >> 12) & 1;
    rest = full & 4095;
    al   = kept + ((g == 1 && (rest != 0 || (kept & 1) == 1)) ? 1 : 0);
    s    = sub ? bigm - al : bigm + al;
    e    = bige;
    ncyc = 1;
    cat  = sub ? "R4" : "R1 R3";
    if (s >= 2048) begin
      s = s >> 1; e = e + 1; ncyc = 2; cat = "R5";
    end else if (s == 0) begin
      cat = "R7";
      return 16'h0000;
    end else begin
      while (s < 1024) begin
        if (e == 1) begin
          cat = "R8";
          return 16'h0000;
        end
        s = s * 2; e = e - 1; ncyc++; cat = "R6";
      end
    end
    return {bs, e[4:0], s[9:0]};
  endfunction

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit gaps);
    logic [10:0] am, bm;
    logic [5:0]  ase, bse;
    logic [10:0] rm;
    logic [5:0]  rs;
    logic [15:0] exp_v, got;
    int ia, ib, j, ncyc;
    bit acc_a, acc_b, seen;
    string cat;
    am = {1'b1, a[9:0]}; bm = {1'b1, b[9:0]};
    ase = {a[15], a[14:10]}; bse = {b[15], b[14:10]};
    exp_v = ref_add(a, b, ncyc, cat);
    ia = 0; ib = 0;
    while (ia < 11 || ib < 11) begin
      @(negedge clk);
      // A lane that is already full keeps offering junk, which must be ignored.
      a_vld = (ia >= 11) || !gaps || ($urandom % 2 == 0);
      a_man = (ia < 11) ? am[ia] : 1'($urandom);
      a_se  = (ia < 6) ? ase[ia] : 1'($urandom);
      b_vld = (ib >= 11) || !gaps || ($urandom % 2 == 0);
      b_man = (ib < 11) ? bm[ib] : 1'($urandom);
      b_se  = (ib < 6) ? bse[ib] : 1'($urandom);
      acc_a = a_vld && a_rdy && ia < 11;
      acc_b = b_vld && b_rdy && ib < 11;
      if (a_vld && a_rdy && ia >= 11) check(0, "R2", 1, 0);
      if (b_vld && b_rdy && ib >= 11) check(0, "R2", 1, 0);
      @(posedge clk);
      if (acc_a) ia++;
      if (acc_b) ib++;
    end
    j = 0; seen = 0;
    while (!seen && j < 400) begin
      @(negedge clk);
      j++;
      if (res_done) begin
        seen = 1;
        a_vld = 1'b0; b_vld = 1'b0;
      end else begin
        a_vld = 1'b1; a_man = 1'($urandom); a_se = 1'($urandom);
        b_vld = 1'b1; b_man = 1'($urandom); b_se = 1'($urandom);
        if (j == 3) check(!a_rdy && !b_rdy, "R2 busy ready", {a_rdy, b_rdy}, 0);
      end
    end
    check(seen && j == 13 + ncyc, "R10 done timing", j, 13 + ncyc);
    if (!seen) return;
    for (int k = 0; k < 11; k++) begin
      if (k > 0) @(negedge clk);
      rm[k] = res_man;
      if (k < 6) rs[k] = res_se;
      check(res_vld && (res_done == (k == 0)) && (res_se_vld == (k < 6)), "R9 beat shape",
            {res_vld, res_done, res_se_vld}, {1'b1, k == 0, k < 6});
    end
    got = {rs[5], rs[4:0], rm[9:0]};
    check(got == exp_v, cat, got, exp_v);
    check(rm[10] == (exp_v[14:10] != 0), "R9 leading bit", rm[10], exp_v[14:10] != 0);
    @(negedge clk);
    check(!res_vld && a_rdy && b_rdy, "R9 R2 stream end", {res_vld, a_rdy, b_rdy}, 3'b011);
  endtask

  function automatic logic [15:0] rnd_half(input int ex);
    return {1'($urandom), ex[4:0], 10'($urandom)};
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(a_rdy && b_rdy && !res_vld && !res_done, "R2 R9 reset state",
          {a_rdy, b_rdy, res_vld, res_done}, 4'b1100);

    run_op(16'h3E00, 16'h3E00, 0);  // R5 carry: 1.5 + 1.5
    run_op(16'h3C00, 16'hBC00, 0);  // R7 exact cancel
    run_op(16'h3C00, 16'h3801, 0);  // R3 tie stays even
    run_op(16'h3C00, 16'h3803, 0);  // R3 tie rounds up
    run_op(16'h3C00, 16'h1000, 0);  // R3 far tie to zero
    run_op(16'h3C00, 16'h1001, 1);  // R3 just above half
    run_op(16'h0600, 16'h8400, 0);  // R8 flush on underflow
    run_op(16'h5001, 16'hD000, 1);  // R6 ten left shifts
    run_op(16'hC500, 16'h4100, 1);  // R4 negative larger operand

    for (int t = 0; t < 300; t++) begin
      int ea, eb;
      logic [15:0] a, b;
      ea = 1 + int'($urandom % 29);
      if ($urandom % 2 == 0) eb = ea + int'($urandom % 5) - 2;
      else eb = 1 + int'($urandom % 29);
      if (eb < 1) eb = 1;
      if (eb > 29) eb = 29;
      a = rnd_half(ea);
      b = rnd_half(eb);
      if ($urandom % 8 == 0) b[9:0] = a[9:0] ^ 10'($urandom % 4);
      run_op(a, b, 1'($urandom));
    end
    finish_up();
  end
endmodule